// File: doc/BRIEF.md
# Prescaled Compare Timer with Event Flags

A 16-bit up-counter advanced by a slow reference tick (nominally 32.768 kHz, delivered as a one-cycle pulse `ref_tick` in the system clock domain), divided by a power-of-two prescaler. Two compare registers are watched on every prescaled tick. A match sets a sticky flag. A match on the second comparator also folds the counter back to zero, so that comparator sets the period of a repeating interval. Each comparator has an event-mode field. When that field is nonzero, its flag drives the level-sensitive interrupt output.

Software reaches the block through four 16-bit word registers. A single control word carries the run bit, the write-one-to-clear flags, a configured marker and the one-time configuration fields. One write to it can therefore stop the counter and acknowledge both events. A typical driver configures the prescale and event mode once. For each interval it then writes the compare-2 value, zeroes the counter and sets the run bit. In the interrupt handler it stops the timer and clears the flags, all in one write to the control word.

Intended intervals lie between 0xF and 0xFFFE prescaled ticks. The block itself accepts any compare value.

Top module: `pct_timer`

## Requirements
- R1: After synchronous reset, all four registers read 0, `irq` is 0 and `rd_data` is 0.
- R2: The word offset `addr` selects the register: 0 is compare 1, 1 is compare 2, 2 is the counter and 3 is the control word. A read strobe returns the selected value on `rd_data` at the next clock edge. The control word reads {run[15], flag2[14], flag1[13], configured[12], 00, mode2[9:8], mode1[7:6], 00, scale[3:0]}.
- R3: The first write to the control word latches scale[3:0], mode1[7:6] and mode2[9:8] and sets configured[12]. Later control writes leave those fields unchanged.
- R4: Every control write loads run from bit 15. While run is 1, a prescaled tick occurs on every 2^scale-th reference tick, and a scale above 8 acts as 8. While run is 0, the counter holds its value.
- R5: A counter write loads the written value at the next edge and takes priority over a tick in the same cycle.
- R6: On a prescaled tick where counter equals compare 2, flag2 sets and the counter becomes 0 instead of incrementing.
- R7: On a prescaled tick where counter equals compare 1, flag1 sets and the counter keeps counting.
- R8: A control write with bit 14 or bit 13 at 1 clears flag2 or flag1 respectively. A 0 in those bits leaves the flag unchanged. A match in the same cycle wins over the clear.
- R9: `irq` is a registered level equal to (flag1 AND mode1≠0) OR (flag2 AND mode2≠0), taken one cycle earlier. It falls in the cycle after the flag is cleared, and it never rises for a comparator whose mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word offset |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong prescaler phase or a bad clamp appears as a counter value that is off by one tick. It becomes visible on the first counter read after 2^scale reference pulses. A wrong fold-back or compare condition shows as a flag bit or counter value that differs within one period of compare 2, and as `irq` edges that land one cycle early or late against the flag timeline. A configuration field that changes on a later write shows on the next read of the control word. A flag that escapes clearing holds `irq` high beyond the single cycle of lag allowed after the clear.

// File: rtl/pct_pkg.sv
package pct_pkg;
  typedef enum logic [1:0] {
    REG_CMP1  = 2'd0,
    REG_CMP2  = 2'd1,
    REG_CNT   = 2'd2,
    REG_SETUP = 2'd3
  } reg_sel_e;

  localparam int BIT_RUN   = 15;
  localparam int BIT_F2    = 14;
  localparam int BIT_F1    = 13;
  localparam int BIT_DONE  = 12;
  localparam int MODE2_LO  = 8;
  localparam int MODE1_LO  = 6;
endpackage

// File: rtl/pct_prescaler.sv
module pct_prescaler #(
  parameter int SCALE_W   = 4,
  parameter int MAX_SCALE = 8,
  parameter int PRE_W     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               ref_tick,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);
  logic [PRE_W-1:0]   pre_q;
  logic [SCALE_W-1:0] eff;
  logic [PRE_W:0]     mask_w;
  logic [PRE_W-1:0]   mask;

  // scale values beyond the supported range saturate
  assign eff    = (scale > SCALE_W'(MAX_SCALE)) ? SCALE_W'(MAX_SCALE) : scale;
  assign mask_w = ((PRE_W+1)'(1) << eff) - (PRE_W+1)'(1);
  assign mask   = mask_w[PRE_W-1:0];
  assign tick   = run && ref_tick && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else if (ref_tick) pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/pct_counter.sv
module pct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wrap,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (wrap) cnt <= '0;
    else if (tick) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/pct_match_flag.sv
module pct_match_flag #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             clr,
  output logic             hit,
  output logic             flag
);
  assign hit = tick && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/pct_timer.sv
module pct_timer
  import pct_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SCALE_W   = 4,
  parameter int MAX_SCALE = 8,
  parameter int MODE_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  localparam int PRE_W = MAX_SCALE;
  localparam int NCMP  = 2;

  logic                         run_q, done_q, irq_q;
  logic [SCALE_W-1:0]           scale_q;
  logic [NCMP-1:0][MODE_W-1:0]  mode_q;
  logic [NCMP-1:0][CNT_W-1:0]   cmp_q;
  logic [NCMP-1:0]              hit, flag, mode_on;
  logic [CNT_W-1:0]             cnt, setup_word, rd_q;
  logic                         setup_wr, cnt_wr, tick;

  assign setup_wr = wr_en && (addr == REG_SETUP);
  assign cnt_wr   = wr_en && (addr == REG_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      scale_q <= '0;
      mode_q  <= '0;
      cmp_q   <= '0;
    end else begin
      if (setup_wr) begin
        run_q <= wr_data[BIT_RUN];
        if (!done_q) begin
          done_q    <= 1'b1;
          scale_q   <= wr_data[SCALE_W-1:0];
          mode_q[0] <= wr_data[MODE1_LO +: MODE_W];
          mode_q[1] <= wr_data[MODE2_LO +: MODE_W];
        end
      end
      for (int i = 0; i < NCMP; i++)
        if (wr_en && (addr == 2'(i))) cmp_q[i] <= wr_data;
    end
  end

  pct_prescaler #(.SCALE_W(SCALE_W), .MAX_SCALE(MAX_SCALE), .PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run(run_q), .ref_tick(ref_tick),
    .scale(scale_q), .tick(tick)
  );

  pct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .wrap(hit[1]),
    .ld(cnt_wr), .ld_val(wr_data), .cnt(cnt)
  );

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    localparam int FB = (g == 0) ? BIT_F1 : BIT_F2;
    pct_match_flag #(.CNT_W(CNT_W)) u_mf (
      .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .cmp(cmp_q[g]),
      .clr(setup_wr && wr_data[FB]), .hit(hit[g]), .flag(flag[g])
    );
    assign mode_on[g] = |mode_q[g];
  end

  always_comb begin
    setup_word                       = '0;
    setup_word[BIT_RUN]              = run_q;
    setup_word[BIT_F2]               = flag[1];
    setup_word[BIT_F1]               = flag[0];
    setup_word[BIT_DONE]             = done_q;
    setup_word[MODE2_LO +: MODE_W]   = mode_q[1];
    setup_word[MODE1_LO +: MODE_W]   = mode_q[0];
    setup_word[SCALE_W-1:0]          = scale_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= |(flag & mode_on);
      if (rd_en) begin
        case (addr)
          REG_CMP1: rd_q <= cmp_q[0];
          REG_CMP2: rd_q <= cmp_q[1];
          REG_CNT:  rd_q <= cnt;
          default:  rd_q <= setup_word;
        endcase
      end
    end
  end

  assign rd_data = rd_q;
  assign irq     = irq_q;
endmodule

// File: rtl/pct_timer_chk.sv
module pct_timer_chk #(
  parameter int CNT_W   = 16,
  parameter int SCALE_W = 4,
  parameter int MODE_W  = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   run_q,
  input logic                   done_q,
  input logic [SCALE_W-1:0]     scale_q,
  input logic [1:0][MODE_W-1:0] mode_q,
  input logic [1:0]             flag,
  input logic [1:0]             hit,
  input logic [CNT_W-1:0]       cnt,
  input logic                   cnt_wr,
  input logic                   irq
);
  p_irq_level_r9: assert property (@(posedge clk) disable iff (rst)
    irq == $past((flag[0] && (mode_q[0] != '0)) || (flag[1] && (mode_q[1] != '0))));

  p_done_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    $past(done_q) |-> done_q);

  p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    $past(done_q) |-> ($stable(scale_q) && $stable(mode_q)));

  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (rst)
    $past(hit[1] && !cnt_wr) |-> (cnt == '0));

  p_flag2_set_r6: assert property (@(posedge clk) disable iff (rst)
    $past(hit[1]) |-> flag[1]);

  p_flag1_set_r7: assert property (@(posedge clk) disable iff (rst)
    $past(hit[0]) |-> flag[0]);

  p_hold_stopped_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!run_q && !cnt_wr) |-> $stable(cnt));
endmodule

bind pct_timer pct_timer_chk #(.CNT_W(CNT_W), .SCALE_W(SCALE_W), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst(rst), .run_q(run_q), .done_q(done_q), .scale_q(scale_q),
  .mode_q(mode_q), .flag(flag), .hit(hit), .cnt(cnt), .cnt_wr(cnt_wr), .irq(irq)
);

// File: tb/pct_timer_tb.sv
module pct_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1, ref_tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] rd_data;
  logic        irq;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pct_timer u_dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  // reference model built from the requirements
  logic        m_run, m_done, m_f1, m_f2, m_irq;
  logic [3:0]  m_scale;
  logic [1:0]  m_m1, m_m2;
  logic [15:0] m_cnt, m_c1, m_c2, m_rd;
  logic [7:0]  m_pre;

  always @(posedge clk) begin : mdl
    int eff;
    logic [8:0] mw;
    logic tk, h1, h2, sw;
    if (rst) begin
      m_run = 0; m_done = 0; m_f1 = 0; m_f2 = 0; m_irq = 0; m_scale = 0;
      m_m1 = 0; m_m2 = 0; m_cnt = 0; m_c1 = 0; m_c2 = 0; m_rd = 0; m_pre = 0;
    end else begin
      eff = (m_scale > 8) ? 8 : int'(m_scale);
      mw  = (9'd1 << eff) - 9'd1;
      tk  = ref_tick && m_run && ((m_pre & mw[7:0]) == mw[7:0]);
      h1  = tk && (m_cnt == m_c1);
      h2  = tk && (m_cnt == m_c2);
      sw  = wr_en && (addr == 2'd3);
      if (rd_en)
        case (addr)
          2'd0: m_rd = m_c1;
          2'd1: m_rd = m_c2;
          2'd2: m_rd = m_cnt;
          default: m_rd = {m_run, m_f2, m_f1, m_done, 2'b00, m_m2, m_m1, 2'b00, m_scale};
        endcase
      m_irq = (m_f1 && m_m1 != 0) || (m_f2 && m_m2 != 0);
      if (!m_run) m_pre = 0; else if (ref_tick) m_pre = m_pre + 8'd1;
      if (wr_en && addr == 2'd2) m_cnt = wr_data;
      else if (h2) m_cnt = 0;
      else if (tk) m_cnt = m_cnt + 16'd1;
      if (h1) m_f1 = 1; else if (sw && wr_data[13]) m_f1 = 0;
      if (h2) m_f2 = 1; else if (sw && wr_data[14]) m_f2 = 0;
      if (sw) begin
        m_run = wr_data[15];
        if (!m_done) begin
          m_done = 1; m_scale = wr_data[3:0]; m_m1 = wr_data[7:6]; m_m2 = wr_data[9:8];
        end
      end
      if (wr_en && addr == 2'd0) m_c1 = wr_data;
      if (wr_en && addr == 2'd1) m_c2 = wr_data;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [1:0] a, input logic [15:0] d,
                      input logic r, input logic rt);
    wr_en = w; addr = a; wr_data = d; rd_en = r; ref_tick = rt;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0; ref_tick = 0;
    check("R9 irq vs model", {15'd0, irq}, {15'd0, m_irq});
    if (r) check("R2 read vs model", rd_data, m_rd);
  endtask

  task automatic rd(input logic [1:0] a);
    step(0, a, 16'd0, 1, 0);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 2'd0, 16'd0, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1: reset state
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 rd_data", rd_data, 16'd0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a));
      check("R1 register zero", rd_data, 16'd0);
    end
    // R2: map
    step(1, 2'd1, 16'd5, 0, 0);
    step(1, 2'd0, 16'd2, 0, 0);
    rd(2'd1); check("R2 compare 2 readback", rd_data, 16'd5);
    rd(2'd0); check("R2 compare 1 readback", rd_data, 16'd2);
    // R3: first setup write latches fields
    step(1, 2'd3, 16'h8300, 0, 0);
    rd(2'd3); check("R3 setup latched", rd_data, 16'h9300);
    step(1, 2'd3, 16'h80CF, 0, 0);
    rd(2'd3); check("R3 later write keeps fields", rd_data, 16'h9300);
    // R5 / R7: load counter, tick through compare 1
    step(1, 2'd2, 16'd0, 0, 0);
    ticks(3);
    rd(2'd2); check("R5 counter after load and 3 ticks", rd_data, 16'd3);
    rd(2'd3); check("R7 flag1 set", rd_data, 16'hB300);
    check("R9 mode1 zero gives no irq", {15'd0, irq}, 16'd0);
    // R6: wrap on compare 2
    ticks(3);
    rd(2'd2); check("R6 counter folded to zero", rd_data, 16'd0);
    rd(2'd3); check("R6 flag2 set", rd_data, 16'hF300);
    check("R9 irq high on flag2", {15'd0, irq}, 16'd1);
    // R8 / R9: clear flag2 only
    step(1, 2'd3, 16'hC000, 0, 0);
    check("R9 irq lags clear by one cycle", {15'd0, irq}, 16'd1);
    step(0, 2'd0, 16'd0, 0, 0);
    check("R9 irq falls after clear", {15'd0, irq}, 16'd0);
    rd(2'd3); check("R8 flag1 kept, flag2 cleared", rd_data, 16'hB300);
    // R4: stop and clear flag1
    step(1, 2'd3, 16'h2000, 0, 0);
    ticks(5);
    rd(2'd2); check("R4 stopped counter holds", rd_data, 16'd0);
    rd(2'd3); check("R8 stop and clear", rd_data, 16'h1300);
    // R4: scale above 8 acts as 8
    do_reset();
    step(1, 2'd1, 16'hFFFE, 0, 0);
    step(1, 2'd3, 16'h800C, 0, 0);
    step(1, 2'd2, 16'd0, 0, 0);
    ticks(255);
    rd(2'd2); check("R4 no tick before 256 ref pulses", rd_data, 16'd0);
    ticks(1);
    rd(2'd2); check("R4 tick on 256th ref pulse", rd_data, 16'd1);
    // random phase
    do_reset();
    step(1, 2'd1, 16'd17, 0, 0);
    step(1, 2'd0, 16'd9, 0, 0);
    step(1, 2'd3, 16'h8000 | 16'(($urandom_range(1, 3)) << 8) |
                  16'(($urandom_range(0, 3)) << 6) | 16'($urandom_range(0, 2)), 0, 0);
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [15:0] d;
      op = $urandom_range(0, 99);
      if (op < 4) begin
        d = 16'($urandom());
        d[15] = ($urandom_range(0, 9) < 8);
        step(1, 2'd3, d, 0, 1'($urandom()));
      end else if (op < 7) begin
        step(1, 2'($urandom_range(0, 2)), 16'($urandom_range(0, 23)), 0, 1'($urandom()));
      end else if (op < 30) begin
        step(0, 2'($urandom_range(0, 3)), 16'd0, 1, 1'($urandom()));
      end else begin
        step(0, 2'd0, 16'd0, 0, 1'($urandom()));
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule